// File: doc/BRIEF.md
# Synchronous Burst Static RAM with Byte Write Decode

This block is a single-port static RAM with one clock. It holds a burst address internally and can write single bytes. Address, write data and every control input take effect on the rising clock edge. Two active-low address strobes each load a new external address and restart a 2-bit burst counter. While neither strobe is asserted, an active-low advance input steps that counter. The counter replaces the two low address bits, in linear order or interleaved order as a select input chooses.

Writes are decoded per byte. An active-low global-write input stores the whole word. Otherwise, when a byte-write qualifier is low, each active-low byte enable stores its own byte. Read data appears on a registered output one clock after the access. A read of a location during a write to it returns the bytes just written. Depth, byte count and byte width are parameters.

Top module: `burst_sram`

## Requirements
- R1: While `rst` is high, `rdata_o` is zero and the burst state is cleared. A later access that has no strobe and no advance uses address 0.
- R2: A cycle with `ctrl_strobe_n` low and `proc_strobe_n` high loads `addr_i` as the access address, resets the burst count to 0 and allows a write in that same cycle.
- R3: When both strobes are low in one cycle, the processor strobe (`proc_strobe_n`) wins: `addr_i` is loaded and the cycle follows R4.
- R4: A cycle with `proc_strobe_n` low is a read. No byte is written, whatever `gwrite_n`, `bwe_n` and `ben_n` show.
- R5: With both strobes high and `adv_n` low, the burst count goes up by one, modulo 4. With `order_sel` = 0 (linear), the two low access address bits are (loaded low bits + count) mod 4, and the upper bits keep their loaded value.
- R6: With `order_sel` = 1 (interleaved), the two low access address bits are the loaded low bits XOR the count.
- R7: With both strobes and `adv_n` high, the access address does not change.
- R8: `gwrite_n` low writes every byte of the accessed word, whatever `bwe_n` and `ben_n` show, except in the case of R4.
- R9: With `gwrite_n` high and `bwe_n` low, byte i (data bits i*8+7 down to i*8) is written exactly when `ben_n[i]` is low.
- R10: With `gwrite_n` high and `bwe_n` high, nothing is written.
- R11: `rdata_o` is registered and shows the accessed word after the edge that performs the access. Bytes written in that same cycle appear with their new value, and the other bytes keep their stored value.
- R12: Four advances from a loaded address bring the access address back to the loaded address, in both orders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | BYTES*BYTE_W | Write data |
| proc_strobe_n | input | 1 | Address strobe that starts a read cycle, active low, takes priority |
| ctrl_strobe_n | input | 1 | Address strobe that allows a write, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwrite_n | input | 1 | Whole-word write, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| ben_n | input | BYTES | Per-byte write enables, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| rdata_o | output | BYTES*BYTE_W | Registered read data |

## Verification
Two functions can fall in the same cycle. One is the change of the burst address, by a load, an advance or a hold. The other is the byte-write decode, which can include a read of the very word being written. Random cycles combine strobes, advance, order and write controls freely. Some directed cycles assert both strobes together with global write, and others partly overwrite a word during an advance. The bench runs its own model of the address and the memory, which predicts each registered read word with the new bytes merged in. A wrong address or a wrong byte mask therefore shows up as a mismatch on `rdata_o`.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        ACC_HOLD    = 2'd0,
        ACC_ADVANCE = 2'd1,
        ACC_LOAD_RD = 2'd2,
        ACC_LOAD_WR = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic load_rd;
        logic load_wr;
        logic step;
    } strobe_t;

    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] count,
                                             input order_e     ord);
        logic [1:0] r;
        if (ord == ORD_INTERLEAVE) r = start ^ count;
        else                       r = start + count;
        return r;
    endfunction

    function automatic acc_kind_e classify(input strobe_t s);
        acc_kind_e k;
        if (s.load_rd)      k = ACC_LOAD_RD;
        else if (s.load_wr) k = ACC_LOAD_WR;
        else if (s.step)    k = ACC_ADVANCE;
        else                k = ACC_HOLD;
        return k;
    endfunction

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  strobe_t           strobes,
    input  order_e            order,
    output logic [ADDR_W-1:0] acc_addr,
    output acc_kind_e         acc_kind
);
    localparam int CNT_W = 2;

    logic [ADDR_W-1:0] base_q, base_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    always_comb begin
        acc_kind = classify(strobes);
        base_d   = base_q;
        cnt_d    = cnt_q;
        unique case (acc_kind)
            ACC_LOAD_RD, ACC_LOAD_WR: begin
                base_d = addr_i;
                cnt_d  = '0;
            end
            ACC_ADVANCE: cnt_d = cnt_q + 2'd1;
            default: ;
        endcase
        acc_addr = {base_d[ADDR_W-1:CNT_W], burst_low(base_d[CNT_W-1:0], cnt_d, order)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            base_q <= base_d;
            cnt_q  <= cnt_d;
        end
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (strobes.load_rd || strobes.load_wr) |=> (base_q == $past(addr_i)) && (cnt_q == 2'd0));

    assert_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!strobes.load_rd && !strobes.load_wr && strobes.step) |=> (cnt_q == $past(cnt_q) + 2'd1));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!strobes.load_rd && !strobes.load_wr && !strobes.step) |=> ($stable(base_q) && $stable(cnt_q)));

endmodule

// File: rtl/byte_write_decode.sv
module byte_write_decode
    import burst_sram_pkg::*;
#(
    parameter int BYTES = 2
) (
    input  acc_kind_e        acc_kind,
    input  logic             gwrite_n,
    input  logic             bwe_n,
    input  logic [BYTES-1:0] ben_n,
    output logic [BYTES-1:0] wmask
);
    logic write_ok;

    assign write_ok = (acc_kind != ACC_LOAD_RD);

    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign wmask[i] = write_ok && (!gwrite_n || (!bwe_n && !ben_n[i]));
    end

endmodule

// File: rtl/sram_bank_array.sv
module sram_bank_array #(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    input  logic [BYTES-1:0]        wmask,
    output logic [BYTES*BYTE_W-1:0] rdata_o
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = BYTES * BYTE_W;

    logic [DATA_W-1:0] merged;

    for (genvar i = 0; i < BYTES; i++) begin : g_bank
        logic [BYTE_W-1:0] cells [DEPTH];
        logic [BYTE_W-1:0] wbyte;

        assign wbyte = wdata[i*BYTE_W +: BYTE_W];
        assign merged[i*BYTE_W +: BYTE_W] = wmask[i] ? wbyte : cells[addr];

        always_ff @(posedge clk) begin
            if (wmask[i]) cells[addr] <= wbyte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_o <= '0;
        else     rdata_o <= merged;
    end

    assert_fwd_R11: assert property (@(posedge clk) disable iff (rst)
        (wmask[0]) |=> (rdata_o[BYTE_W-1:0] == $past(wdata[BYTE_W-1:0])));

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8,
    localparam int DATA_W = BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              adv_n,
    input  logic              gwrite_n,
    input  logic              bwe_n,
    input  logic [BYTES-1:0]  ben_n,
    input  logic              order_sel,
    output logic [DATA_W-1:0] rdata_o
);
    strobe_t           strobes;
    acc_kind_e         acc_kind;
    logic [ADDR_W-1:0] acc_addr;
    logic [BYTES-1:0]  wmask;

    assign strobes = '{load_rd: !proc_strobe_n, load_wr: !ctrl_strobe_n, step: !adv_n};

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .addr_i   (addr_i),
        .strobes  (strobes),
        .order    (order_e'(order_sel)),
        .acc_addr (acc_addr),
        .acc_kind (acc_kind)
    );

    byte_write_decode #(.BYTES(BYTES)) u_dec (
        .acc_kind (acc_kind),
        .gwrite_n (gwrite_n),
        .bwe_n    (bwe_n),
        .ben_n    (ben_n),
        .wmask    (wmask)
    );

    sram_bank_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .addr    (acc_addr),
        .wdata   (wdata_i),
        .wmask   (wmask),
        .rdata_o (rdata_o)
    );

    assert_readonly_R4: assert property (@(posedge clk) disable iff (rst)
        (!proc_strobe_n) |-> (wmask == '0));

    assert_prio_R3: assert property (@(posedge clk) disable iff (rst)
        (!proc_strobe_n && !ctrl_strobe_n) |-> (acc_addr == addr_i) && (wmask == '0));

    assert_global_R8: assert property (@(posedge clk) disable iff (rst)
        (proc_strobe_n && !gwrite_n) |-> (&wmask));

    assert_nowrite_R10: assert property (@(posedge clk) disable iff (rst)
        (gwrite_n && bwe_n) |-> (wmask == '0));

endmodule

// File: tb/burst_sram_test.sv
module burst_sram_test;
    localparam int AW = 8;
    localparam int NB = 2;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic          proc_strobe_n = 1'b1;
    logic          ctrl_strobe_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          gwrite_n = 1'b1;
    logic          bwe_n = 1'b1;
    logic [NB-1:0] ben_n = '1;
    logic          order_sel = 1'b0;
    logic [DW-1:0] rdata_o;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] ref_mem [1 << AW];
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;

    always #2.5 clk = ~clk;

    burst_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(8)) uut (
        .clk(clk), .rst(rst), .addr_i(addr_i), .wdata_i(wdata_i),
        .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n), .adv_n(adv_n),
        .gwrite_n(gwrite_n), .bwe_n(bwe_n), .ben_n(ben_n), .order_sel(order_sel),
        .rdata_o(rdata_o)
    );

    function automatic logic [1:0] exp_low(input logic [1:0] s, input logic [1:0] c, input bit ord);
        return ord ? (s ^ c) : 2'((s + c) & 2'd3);
    endfunction

    function automatic logic [NB-1:0] exp_mask(input bit wr_ok, input bit g, input bit bw, input logic [NB-1:0] be);
        if (!wr_ok) return '0;
        if (!g)     return '1;
        if (!bw)    return ~be;
        return '0;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; adv_n = 1'b1;
        gwrite_n = 1'b1; bwe_n = 1'b1; ben_n = '1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        m_base = '0; m_cnt = '0;
        check("R1 reset output", rdata_o, '0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input bit p, input bit c, input bit a, input bit g, input bit bw,
                        input logic [NB-1:0] be, input bit ord,
                        input logic [AW-1:0] ad, input logic [DW-1:0] wd, input string tag);
        bit            wr_ok;
        logic [AW-1:0] acc;
        logic [NB-1:0] mk;
        logic [DW-1:0] word;
        @(negedge clk);
        proc_strobe_n = p; ctrl_strobe_n = c; adv_n = a;
        gwrite_n = g; bwe_n = bw; ben_n = be; order_sel = ord;
        addr_i = ad; wdata_i = wd;
        wr_ok = 1'b1;
        if (!p) begin
            m_base = ad; m_cnt = 2'd0; wr_ok = 1'b0;
        end else if (!c) begin
            m_base = ad; m_cnt = 2'd0;
        end else if (!a) begin
            m_cnt = m_cnt + 2'd1;
        end
        acc  = {m_base[AW-1:2], exp_low(m_base[1:0], m_cnt, ord)};
        mk   = exp_mask(wr_ok, g, bw, be);
        word = ref_mem[acc];
        for (int i = 0; i < NB; i++)
            if (mk[i]) word[i*8 +: 8] = wd[i*8 +: 8];
        ref_mem[acc] = word;
        @(posedge clk); #1;
        check(tag, rdata_o, word);
    endtask

    function automatic string rand_tag(input bit p, input bit c, input bit a, input bit ord,
                                       input bit g, input bit bw);
        string at, wt;
        if (!p && !c)  at = "R3";
        else if (!p)   at = "R4";
        else if (!c)   at = "R2";
        else if (!a)   at = ord ? "R6" : "R5";
        else           at = "R7";
        if (!p)        wt = "R4";
        else if (!g)   wt = "R8";
        else if (!bw)  wt = "R9";
        else           wt = "R10";
        return {at, "/", wt, "/R11"};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        for (int i = 0; i < (1 << AW); i++)
            step(1, 0, 1, 0, 1, 2'b11, 0, AW'(i), {8'(i) ^ 8'hA5, 8'(i)}, "R2/R8/R11 fill");

        do_reset();
        step(1, 1, 1, 1, 1, 2'b11, 0, 8'hFF, 16'hDEAD, "R1 address cleared to zero");

        step(1, 0, 1, 1, 1, 2'b11, 0, 8'h35, 16'h0000, "R2 load read");
        for (int k = 0; k < 4; k++)
            step(1, 1, 0, 1, 1, 2'b11, 0, 8'h00, 16'h0000, "R5/R12 linear wrap");
        step(1, 1, 1, 1, 1, 2'b11, 0, 8'h00, 16'h0000, "R7 hold after wrap");

        step(1, 0, 1, 1, 1, 2'b11, 1, 8'h36, 16'h0000, "R2 load read");
        for (int k = 0; k < 4; k++)
            step(1, 1, 0, 1, 1, 2'b11, 1, 8'h00, 16'h0000, "R6/R12 interleaved wrap");

        step(0, 0, 1, 0, 0, 2'b00, 0, 8'h40, 16'h1234, "R3/R4 both strobes with global write");
        step(1, 0, 1, 1, 1, 2'b11, 0, 8'h40, 16'h0000, "R3/R4 word unchanged");
        step(1, 0, 1, 1, 0, 2'b10, 0, 8'h41, 16'hBEEF, "R9 low byte only");
        step(1, 1, 0, 1, 0, 2'b01, 0, 8'h00, 16'hCAFE, "R9/R11 high byte during advance");
        step(1, 1, 1, 1, 1, 2'b00, 0, 8'h00, 16'h7777, "R10 no write with qualifier off");
        step(1, 1, 1, 0, 1, 2'b11, 0, 8'h00, 16'h5A5A, "R8 global write ignores enables");

        for (int n = 0; n < 3000; n++) begin
            bit p, c, a, g, bw, ord;
            logic [NB-1:0] be;
            p   = ($urandom % 100) < 15 ? 1'b0 : 1'b1;
            c   = ($urandom % 100) < 20 ? 1'b0 : 1'b1;
            a   = $urandom % 2;
            g   = ($urandom % 100) < 20 ? 1'b0 : 1'b1;
            bw  = $urandom % 2;
            be  = NB'($urandom);
            ord = $urandom % 2;
            step(p, c, a, g, bw, be, ord, AW'($urandom), DW'($urandom),
                 rand_tag(p, c, a, ord, g, bw));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule